// File: doc/BRIEF.md
# Tag-Checked Instruction Fetch Front End

This block forms the front of a decoupled pipelined processor. A fetch stage keeps its own copy of the program counter. It reads one word per slot from a synchronous instruction array, then advances its copy. It hands each word to decode along with the counter value used to read it, which serves as a tag. Decode holds the architectural program counter and accepts a word only when the tag equals that counter. A word with any other tag is dropped silently. No flush signal is needed, because a wrong-path word can never match.

Decode resolves three kinds of control transfer: a branch on a nonzero register, a jump relative to the counter, and a jump to an address held in a register. A taken transfer updates the decode counter and sends the new target to fetch. In that cycle the target takes priority over the sequential increment. The word fetched in that same cycle keeps the old tag, so it becomes a one-slot bubble. Decode reads register values through a single combinational port. A stall input models a decode stage that is not ready, and fetch then holds its word and its counter.

Top module: `tf_front`

## Requirements
- R1: After reset, out_valid_o is low. Both counters start at START, so the first instruction emitted has pc START.
- R2: Without stalls or redirects, decode emits instructions at consecutive addresses, one per cycle. Opcodes other than 1, 2 and 3 advance the counter by one.
- R3: Each emitted out_instr_o equals the word stored at out_pc_o. A word fetched with a tag that differs from the decode counter is never emitted.
- R4: Opcode 1 in bits [15:12] is a branch on the register named in bits [11:8]. If that register is nonzero, the counter moves by the sign-extended offset in bits [7:0].
- R5: When the opcode 1 branch register is zero, the next instruction is at pc+1 and follows in the next cycle, with no bubble.
- R6: Opcode 2 always sets the counter to pc plus the sign-extended offset in bits [7:0].
- R7: Opcode 3 sets the counter to the low address bits of the register named in bits [11:8]. rf_addr_o presents bits [11:8] of the word being decoded.
- R8: A taken redirect leaves exactly one empty output cycle before the target when the target is not pc+1. When the target is pc+1, the target follows at once, and the duplicate fetch of it causes one empty cycle after it.
- R9: In the cycle after stall_i is high, out_valid_o is low. Across a stall, no instruction is lost or repeated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| imem_we_i | input | 1 | Instruction array write enable |
| imem_waddr_i | input | AW | Instruction array write address |
| imem_wdata_i | input | 16 | Instruction array write data |
| stall_i | input | 1 | Decode not ready |
| rf_addr_o | output | 4 | Register index read by decode |
| rf_data_i | input | XW | Register value for rf_addr_o |
| out_valid_o | output | 1 | Accepted instruction valid |
| out_pc_o | output | AW | Address of accepted instruction |
| out_instr_o | output | 16 | Accepted instruction word |

## Verification
Two events can fall in the same cycle: a redirect from decode and the sequential fetch advance. When they do, the new target must win, and the word fetched in that cycle must still carry the old counter. Every taken branch and jump provokes this collision, including a deliberate jump to pc+1, whose stale-tagged word is in fact correct. The bench judges the result with a cycle-level model of both counters, which predicts the exact cycle and pc of every output and checks the bubble and duplicate-fetch timing, both with and without random stalls.

// File: rtl/tf_pkg.sv
package tf_pkg;
  localparam int IW   = 16;
  localparam int OPW  = 4;
  localparam int RW   = 4;
  localparam int OFFW = 8;

  localparam logic [OPW-1:0] OP_BNZ = 4'h1;
  localparam logic [OPW-1:0] OP_JMP = 4'h2;
  localparam logic [OPW-1:0] OP_JR  = 4'h3;

  typedef struct packed {
    logic [OPW-1:0]  op;
    logic [RW-1:0]   rs;
    logic [OFFW-1:0] off;
  } instr_t;
endpackage

// File: rtl/tf_imem.sv
module tf_imem
  import tf_pkg::*;
#(
  parameter int AW = 10
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [IW-1:0] wdata_i,
  input  logic          re_i,
  input  logic [AW-1:0] raddr_i,
  output logic [IW-1:0] rdata_o
);
  localparam int DEPTH = 1 << AW;

  logic [IW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
    if (re_i) rdata_o <= mem_q[raddr_i];
  end
endmodule

// File: rtl/tf_fetch.sv
module tf_fetch #(
  parameter int          AW    = 10,
  parameter logic [AW-1:0] START = '0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          redir_valid_i,
  input  logic [AW-1:0] redir_pc_i,
  input  logic          ready_i,
  output logic          q_valid_o,
  output logic [AW-1:0] q_tag_o,
  output logic          mem_re_o,
  output logic [AW-1:0] mem_addr_o
);
  logic [AW-1:0] fpc_q;
  logic          advance;

  assign advance    = !q_valid_o || ready_i;
  assign mem_re_o   = advance;
  assign mem_addr_o = fpc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fpc_q     <= START;
      q_valid_o <= 1'b0;
      q_tag_o   <= '0;
    end else begin
      if (advance) begin
        q_valid_o <= 1'b1;
        q_tag_o   <= fpc_q;   // tag is the pre-redirect counter
      end
      if (redir_valid_i)  fpc_q <= redir_pc_i;
      else if (advance)   fpc_q <= fpc_q + AW'(1);
    end
  end

  a_r3_tag_is_fetch_pc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    advance |=> q_valid_o && q_tag_o == $past(fpc_q));
  a_r2_seq_increment: assert property (@(posedge clk_i) disable iff (!rst_ni)
    advance && !redir_valid_i |=> fpc_q == $past(fpc_q) + AW'(1));
  a_r8_redirect_priority: assert property (@(posedge clk_i) disable iff (!rst_ni)
    redir_valid_i |=> fpc_q == $past(redir_pc_i));
  a_r9_hold_on_stall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    q_valid_o && !ready_i && !redir_valid_i |=> q_valid_o && $stable(q_tag_o) && $stable(fpc_q));
endmodule

// File: rtl/tf_decode.sv
module tf_decode
  import tf_pkg::*;
#(
  parameter int            AW    = 10,
  parameter int            XW    = 16,
  parameter logic [AW-1:0] START = '0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          stall_i,
  input  logic          q_valid_i,
  input  logic [AW-1:0] q_tag_i,
  input  logic [IW-1:0] q_instr_i,
  output logic          ready_o,
  output logic [RW-1:0] rf_addr_o,
  input  logic [XW-1:0] rf_data_i,
  output logic          redir_valid_o,
  output logic [AW-1:0] redir_pc_o,
  output logic          out_valid_o,
  output logic [AW-1:0] out_pc_o,
  output logic [IW-1:0] out_instr_o
);
  instr_t        ins;
  logic [AW-1:0] dpc_q, off_ext, target;
  logic          fire, match, accept, taken;

  assign ins       = q_instr_i;
  assign ready_o   = !stall_i;
  assign fire      = q_valid_i && ready_o;
  assign match     = q_tag_i == dpc_q;
  assign accept    = fire && match;
  assign rf_addr_o = ins.rs;
  assign off_ext   = {{(AW-OFFW){ins.off[OFFW-1]}}, ins.off};

  always_comb begin
    taken  = 1'b0;
    target = dpc_q + off_ext;
    unique case (ins.op)
      OP_BNZ:  taken = rf_data_i != '0;
      OP_JMP:  taken = 1'b1;
      OP_JR: begin
        taken  = 1'b1;
        target = rf_data_i[AW-1:0];
      end
      default: taken = 1'b0;
    endcase
  end

  assign redir_valid_o = accept && taken;
  assign redir_pc_o    = target;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dpc_q       <= START;
      out_valid_o <= 1'b0;
      out_pc_o    <= '0;
      out_instr_o <= '0;
    end else begin
      out_valid_o <= accept;
      if (accept) begin
        out_pc_o    <= dpc_q;
        out_instr_o <= q_instr_i;
        dpc_q       <= taken ? target : dpc_q + AW'(1);
      end
    end
  end

  a_r3_drop_mismatch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire && !match |=> !out_valid_o);
  a_r5_not_taken_no_redirect: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept && ins.op == OP_BNZ && rf_data_i == '0 |-> !redir_valid_o);
  a_r6_jump_redirects: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept && ins.op == OP_JMP |-> redir_valid_o);
  a_r9_no_output_after_stall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_i |=> !out_valid_o);
endmodule

// File: rtl/tf_front.sv
module tf_front
  import tf_pkg::*;
#(
  parameter int            AW    = 10,
  parameter int            XW    = 16,
  parameter logic [AW-1:0] START = '0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          imem_we_i,
  input  logic [AW-1:0] imem_waddr_i,
  input  logic [IW-1:0] imem_wdata_i,
  input  logic          stall_i,
  output logic [RW-1:0] rf_addr_o,
  input  logic [XW-1:0] rf_data_i,
  output logic          out_valid_o,
  output logic [AW-1:0] out_pc_o,
  output logic [IW-1:0] out_instr_o
);
  logic          redir_valid, ready, q_valid, mem_re;
  logic [AW-1:0] redir_pc, q_tag, mem_addr;
  logic [IW-1:0] q_instr;

  tf_imem #(.AW(AW)) u_imem (
    .clk_i   (clk_i),
    .we_i    (imem_we_i),
    .waddr_i (imem_waddr_i),
    .wdata_i (imem_wdata_i),
    .re_i    (mem_re),
    .raddr_i (mem_addr),
    .rdata_o (q_instr)
  );

  tf_fetch #(.AW(AW), .START(START)) u_fetch (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .redir_valid_i (redir_valid),
    .redir_pc_i    (redir_pc),
    .ready_i       (ready),
    .q_valid_o     (q_valid),
    .q_tag_o       (q_tag),
    .mem_re_o      (mem_re),
    .mem_addr_o    (mem_addr)
  );

  tf_decode #(.AW(AW), .XW(XW), .START(START)) u_decode (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .stall_i       (stall_i),
    .q_valid_i     (q_valid),
    .q_tag_i       (q_tag),
    .q_instr_i     (q_instr),
    .ready_o       (ready),
    .rf_addr_o     (rf_addr_o),
    .rf_data_i     (rf_data_i),
    .redir_valid_o (redir_valid),
    .redir_pc_o    (redir_pc),
    .out_valid_o   (out_valid_o),
    .out_pc_o      (out_pc_o),
    .out_instr_o   (out_instr_o)
  );
endmodule

// File: tb/tf_front_tb.sv
module tf_front_tb;
  localparam int AW    = 10;
  localparam int XW    = 16;
  localparam int DEPTH = 1 << AW;
  localparam logic [AW-1:0] START = '0;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          imem_we = 1'b0;
  logic [AW-1:0] imem_waddr = '0;
  logic [15:0]   imem_wdata = '0;
  logic          stall = 1'b0;
  logic [3:0]    rf_addr;
  logic [XW-1:0] rf_data;
  logic          out_valid;
  logic [AW-1:0] out_pc;
  logic [15:0]   out_instr;

  always #2.5 clk = ~clk;

  tf_front #(.AW(AW), .XW(XW), .START(START)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .imem_we_i(imem_we), .imem_waddr_i(imem_waddr),
    .imem_wdata_i(imem_wdata), .stall_i(stall), .rf_addr_o(rf_addr), .rf_data_i(rf_data),
    .out_valid_o(out_valid), .out_pc_o(out_pc), .out_instr_o(out_instr)
  );

  logic [15:0]   mem_m [DEPTH];
  logic [XW-1:0] regs [16];
  assign rf_data = regs[rf_addr];

  int errors = 0, checks = 0;
  bit done = 0;

  // cycle model state
  logic          m_qv;
  logic [AW-1:0] m_fpc, m_dpc, m_qtag, m_opc;
  logic          m_ov, m_prev_stall;
  int            redir_age;
  string         reach_rq, out_rq;

  task automatic check(input bit ok, input string rq, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", rq, what, act, exp);
    end
  endtask

  function automatic void exec(input logic [AW-1:0] pc, input logic [15:0] ins,
                               output logic tk, output logic [AW-1:0] tgt, output string rq);
    logic [AW-1:0] off;
    off = {{(AW-8){ins[7]}}, ins[7:0]};
    tk  = 1'b0;
    tgt = pc + AW'(1);
    rq  = "R2";
    case (ins[15:12])
      4'h1: begin
        tk = regs[ins[11:8]] != '0;
        if (tk) begin tgt = pc + off; rq = "R4"; end
        else rq = "R5";
      end
      4'h2: begin tk = 1'b1; tgt = pc + off; rq = "R6"; end
      4'h3: begin tk = 1'b1; tgt = regs[ins[11:8]][AW-1:0]; rq = "R7"; end
      default: ;
    endcase
  endfunction

  task automatic step(input logic s);
    logic          tk, redir;
    logic [AW-1:0] tgt;
    string         rq;
    redir = 1'b0;
    tgt   = '0;
    m_ov  = 1'b0;
    if (m_qv && !s && m_qtag == m_dpc) begin
      exec(m_dpc, mem_m[m_dpc], tk, tgt, rq);
      m_ov     = 1'b1;
      m_opc    = m_dpc;
      out_rq   = reach_rq;
      reach_rq = rq;
      m_dpc    = tgt;
      redir    = tk;
    end
    if (!m_qv || !s) begin
      m_qv   = 1'b1;
      m_qtag = m_fpc;
      m_fpc  = redir ? tgt : m_fpc + AW'(1);
    end
    redir_age    = redir ? 0 : redir_age + 1;
    m_prev_stall = s;
  endtask

  task automatic compare();
    string rq;
    rq = m_prev_stall ? "R9" : (redir_age <= 2 ? "R8" : "R2");
    check(out_valid == m_ov, rq, "out_valid", int'(out_valid), int'(m_ov));
    if (m_ov && out_valid) begin
      check(out_pc == m_opc, out_rq, "out_pc", int'(out_pc), int'(m_opc));
      check(out_instr == mem_m[m_opc], "R3", "out_instr", int'(out_instr), int'(mem_m[m_opc]));
    end
  endtask

  function automatic logic [15:0] rand_instr();
    int r;
    logic [7:0] off;
    r   = $urandom_range(99);
    off = 8'($urandom_range(1, 255));
    if (r < 55)      return {4'h0, 12'($urandom)};
    else if (r < 65) return {4'($urandom_range(4, 15)), 12'($urandom)};
    else if (r < 82) return {4'h1, 4'($urandom), off};
    else if (r < 94) return {4'h2, 4'h0, off};
    else             return {4'h3, 4'($urandom), 8'h00};
  endfunction

  initial begin
    void'($urandom(32'h5eed));
    for (int i = 0; i < DEPTH; i++) mem_m[i] = rand_instr();
    for (int i = 0; i < 16; i++)
      regs[i] = ($urandom_range(3) == 0) ? '0 : XW'($urandom_range(100, DEPTH - 1));
    regs[0] = '0; regs[1] = 16'd5; regs[2] = 16'd20; regs[3] = '0;
    // directed prefix
    mem_m[0]  = 16'h0000;   // seq
    mem_m[1]  = 16'h0123;   // seq
    mem_m[2]  = 16'h1005;   // R5: r0 zero, not taken
    mem_m[3]  = 16'h1104;   // R4: r1 nonzero -> 7
    mem_m[7]  = 16'h2001;   // R8: jump to pc+1
    mem_m[8]  = 16'h3200;   // R7: r2 = 20
    mem_m[20] = 16'h4000;   // other opcode, sequential
    mem_m[21] = 16'h0000;
    mem_m[22] = 16'h204E;   // R6: -> 100
    mem_m[100] = 16'h20FE;  // R6: backward -> 98
    mem_m[98]  = 16'h0000;
    mem_m[99]  = 16'h0000;

    for (int i = 0; i < DEPTH; i++) begin
      @(negedge clk);
      imem_we = 1'b1; imem_waddr = AW'(i); imem_wdata = mem_m[i];
    end
    @(negedge clk);
    imem_we = 1'b0;
    m_qv = 1'b0; m_fpc = START; m_dpc = START; m_qtag = '0; m_opc = '0;
    m_ov = 1'b0; m_prev_stall = 1'b0; redir_age = 10; reach_rq = "R1"; out_rq = "R1";
    rst_ni = 1'b1;
    check(out_valid == 1'b0, "R1", "out_valid after reset", int'(out_valid), 0);
    stall = 1'b0;
    step(1'b0);
    for (int c = 0; c < 6000; c++) begin
      @(negedge clk);
      compare();
      if (c >= 40 && c < 45)      stall = 1'b1;
      else if (c < 60)            stall = 1'b0;
      else if (c < 3000)          stall = ($urandom_range(3) == 0);
      else                        stall = ($urandom_range(9) == 0);
      step(stall);
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule